// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. A root input gives the base of the first-level directory. The walker takes one request at a time. A request carries the virtual address, a write flag and a user-mode flag. The walker reads the directory entry first. It then either resolves a 4 MB page straight away or reads a second-level table entry to resolve a 4 KB page. It returns one response pulse that carries either the physical address or a fault with a three-bit cause code.

The walker also checks permissions. The read/write and user/supervisor bits of both levels are combined by AND, and supervisor accesses are never refused. After a successful translation, the walker marks the entries it used as accessed, and as dirty for a write, by writing them back to memory. It skips any write-back whose bits are already set. The memory port is a plain request/acknowledge port for 32-bit words, and it may hold the acknowledge back for any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: The directory entry is read at `{root_base[31:12], va[31:22], 2'b00}`. For a 4 KB page, the table entry is then read at `{dir_entry[31:12], va[21:12], 2'b00}`.
- R3: A 4 KB translation returns `rsp_fault`=0 and `rsp_paddr` = `{table_entry[31:12], va[11:0]}`. Entry bits 9 to 11 have no effect.
- R4: When directory entry bit 7 is 1 (large page), only one read is made and `rsp_paddr` = `{dir_entry[31:22], va[21:0]}`.
- R5: If entry bit 0 (present) is 0 at either level, the response has `rsp_fault`=1 and `rsp_code` = {user, write, 0}. Bit 2 of the code is the user flag and bit 1 is the write flag.
- R6: The effective bit 1 (writable) and bit 2 (user allowed) are the AND over the levels used. A user access to a page whose effective bit 2 is 0 gives a protection fault, `rsp_code` = {user, write, 1}. So does a user write to a page whose effective bit 1 is 0. Supervisor accesses never take a protection fault.
- R7: On success, the directory entry is rewritten with bit 5 (accessed) set, and the 4 KB leaf entry is also rewritten with bit 5 set. Bit 6 (dirty) is set in the leaf only for a write, and for a large page the leaf is the directory entry. All other bits are kept. The directory is written before the table. No write is made for an entry whose needed bits are already set, and no write is made on a fault.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the response. `rsp_valid` is a one-cycle pulse, and `req_ready` is 1 again in the cycle after it.
- R9: `mem_req` is held, with `mem_addr` and `mem_we` stable, until a cycle with `mem_ack`=1. Read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Directory base; low 12 bits ignored |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of entry |
| mem_wdata | output | 32 | Entry write data |
| mem_rdata | input | 32 | Entry read data, valid with ack |
| mem_ack | input | 1 | Memory access completes |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation faulted |
| rsp_paddr | output | 32 | Physical address (when no fault) |
| rsp_code | output | 3 | Fault cause: bit0 protection, bit1 write, bit2 user |

## Verification
Most internal errors show up at the memory port within one to three cycles of the directory read. A wrong latched entry or index sends the second read, or a write-back, to an unexpected address. A wrong permission or present decision shows up one response later as a swapped fault bit or as a write-back that should not happen, and the bench finds it by reading back its memory model. A state error shows up as `req_ready` rising during the walk or as a stretched response pulse, and the bench sees this on every transaction.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2*IDX_W+OFF_W-1:0]      root_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]      req_vaddr,
  input  logic                          req_write,
  input  logic                          req_user,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [2*IDX_W+OFF_W-1:0]      mem_addr,
  output logic [2*IDX_W+OFF_W-1:0]      mem_wdata,
  input  logic [2*IDX_W+OFF_W-1:0]      mem_rdata,
  input  logic                          mem_ack,
  output logic                          rsp_valid,
  output logic                          rsp_fault,
  output logic [2*IDX_W+OFF_W-1:0]      rsp_paddr,
  output logic [2:0]                    rsp_code
);
  localparam int EW   = 2*IDX_W + OFF_W;
  localparam int LG_W = IDX_W + OFF_W;
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;
  localparam logic [EW-1:0] M_A = EW'(1) << B_A;
  localparam logic [EW-1:0] M_D = EW'(1) << B_D;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_WDIR, S_WTBL, S_RSP} st_t;
  st_t st;

  logic [EW-1:0] va_q, root_q, pde_q, pte_q;
  logic          wr_q, usr_q, lg_q;

  wire [IDX_W-1:0] dir_idx  = va_q[EW-1 -: IDX_W];
  wire [IDX_W-1:0] tbl_idx  = va_q[OFF_W +: IDX_W];
  wire [EW-1:0]    dir_addr = {root_q[EW-1:OFF_W], dir_idx, 2'b00};
  wire [EW-1:0]    tbl_addr = {pde_q[EW-1:OFF_W], tbl_idx, 2'b00};

  wire eff_rw  = mem_rdata[B_RW] & ((st == S_TBL) ? pde_q[B_RW] : 1'b1);
  wire eff_us  = mem_rdata[B_US] & ((st == S_TBL) ? pde_q[B_US] : 1'b1);
  wire prot    = usr_q & (~eff_us | (wr_q & ~eff_rw));
  wire rd_wb   = ~mem_rdata[B_A] | (wr_q & ~mem_rdata[B_D]);
  wire pte_wb  = ~pte_q[B_A] | (wr_q & ~pte_q[B_D]);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign mem_req   = (st == S_DIR) | (st == S_TBL) | (st == S_WDIR) | (st == S_WTBL);
  assign mem_we    = (st == S_WDIR) | (st == S_WTBL);
  assign mem_addr  = ((st == S_DIR) | (st == S_WDIR)) ? dir_addr : tbl_addr;
  assign mem_wdata = (st == S_WDIR) ? (pde_q | M_A | ((lg_q & wr_q) ? M_D : '0))
                                    : (pte_q | M_A | (wr_q ? M_D : '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      root_q    <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      lg_q      <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_code  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          root_q <= root_base;
          st     <= S_DIR;
        end
        S_DIR: if (mem_ack) begin
          pde_q     <= mem_rdata;
          lg_q      <= mem_rdata[B_PS];
          rsp_code  <= {usr_q, wr_q, mem_rdata[B_P] & prot};
          rsp_fault <= ~mem_rdata[B_P] | (mem_rdata[B_PS] & prot);
          rsp_paddr <= {mem_rdata[EW-1 -: IDX_W], va_q[LG_W-1:0]};
          if (!mem_rdata[B_P])       st <= S_RSP;
          else if (mem_rdata[B_PS])  st <= prot ? S_RSP : (rd_wb ? S_WDIR : S_RSP);
          else                       st <= S_TBL;
        end
        S_TBL: if (mem_ack) begin
          pte_q     <= mem_rdata;
          rsp_code  <= {usr_q, wr_q, mem_rdata[B_P] & prot};
          rsp_fault <= ~mem_rdata[B_P] | prot;
          rsp_paddr <= {mem_rdata[EW-1:OFF_W], va_q[OFF_W-1:0]};
          if (!mem_rdata[B_P] || prot) st <= S_RSP;
          else if (!pde_q[B_A])        st <= S_WDIR;
          else if (rd_wb)              st <= S_WTBL;
          else                         st <= S_RSP;
        end
        S_WDIR: if (mem_ack) st <= (!lg_q && pte_wb) ? S_WTBL : S_RSP;
        S_WTBL: if (mem_ack) st <= S_RSP;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r6_prot_user_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_code[0]) |-> rsp_code[2]);

  a_r7_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_A]);

  a_r1_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] root_base = 32'h0000_1ABC;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, mem_req, mem_we, mem_ack, rsp_valid, rsp_fault;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_paddr;
  logic [2:0] rsp_code;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_code(rsp_code)
  );

  logic [31:0] mem [0:4095];
  logic [31:0] rd_log [0:255];
  logic poke_en = 1'b0;
  logic [11:0] poke_idx = '0;
  logic [31:0] poke_val = '0;
  logic slow = 1'b0, tick = 1'b0;
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, fails = 0;

  assign mem_ack   = mem_req && (!slow || tick);
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    tick <= ~tick;
    if (poke_en) mem[poke_idx] <= poke_val;
    else if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_log[rd_cnt[7:0]] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] val);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = addr[13:2]; poke_val = val;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [31:0] addr);
    return mem[addr[13:2]];
  endfunction

  task automatic translate(input logic [31:0] va, input logic w, input logic u,
                           output logic flt, output logic [31:0] pa, output logic [2:0] code,
                           output int base, output int nrd, output int nwr);
    int w0, busy_bad;
    @(negedge clk);
    base = rd_cnt; w0 = wr_cnt;
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 0;
    for (int i = 0; i < 200 && !rsp_valid; i++) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
    end
    chk("R8", "ready high while busy", 32'(busy_bad), 32'd0);
    flt = rsp_fault; pa = rsp_paddr; code = rsp_code;
    @(negedge clk);
    chk("R8", "pulse width / ready return", {30'd0, rsp_valid, req_ready}, 32'd1);
    nrd = rd_cnt - base; nwr = wr_cnt - w0;
  endtask

  logic f; logic [31:0] pa; logic [2:0] cd; int b, nr, nw;

  task automatic t_reset;
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_small_read;
    translate(32'h0040_3123, 1'b0, 1'b1, f, pa, cd, b, nr, nw);
    chk("R2", "dir addr", rd_log[b[7:0]], 32'h0000_1004);
    chk("R2", "tbl addr", rd_log[8'(b+1)], 32'h0000_200C);
    chk("R3", "fault", {31'd0, f}, 32'd0);
    chk("R3", "paddr", pa, 32'h1234_5123);
    chk("R7", "writes", 32'(nw), 32'd2);
    chk("R7", "dir accessed", peek(32'h1004), 32'h0000_2027);
    chk("R7", "leaf accessed, bits 9-11 kept", peek(32'h200C), 32'h1234_5E27);
  endtask

  task automatic t_small_write;
    translate(32'h0040_3123, 1'b1, 1'b1, f, pa, cd, b, nr, nw);
    chk("R3", "paddr write", pa, 32'h1234_5123);
    chk("R7", "only leaf written", 32'(nw), 32'd1);
    chk("R7", "leaf dirty", peek(32'h200C), 32'h1234_5E67);
    translate(32'h0040_3123, 1'b1, 1'b1, f, pa, cd, b, nr, nw);
    chk("R7", "no write when set", 32'(nw), 32'd0);
    chk("R3", "reads", 32'(nr), 32'd2);
  endtask

  task automatic t_large;
    translate(32'h8012_3456, 1'b1, 1'b1, f, pa, cd, b, nr, nw);
    chk("R4", "single read", 32'(nr), 32'd1);
    chk("R2", "dir addr large", rd_log[b[7:0]], 32'h0000_1800);
    chk("R4", "paddr", pa, 32'hABD2_3456);
    chk("R7", "large leaf A+D", peek(32'h1800), 32'hABC0_00E7);
  endtask

  task automatic t_np;
    translate(32'hC000_0000, 1'b1, 1'b1, f, pa, cd, b, nr, nw);
    chk("R5", "dir np fault", {31'd0, f}, 32'd1);
    chk("R5", "dir np code", {29'd0, cd}, 32'd6);
    chk("R7", "no write on fault", 32'(nw), 32'd0);
    translate(32'h0040_5000, 1'b0, 1'b0, f, pa, cd, b, nr, nw);
    chk("R5", "tbl np fault", {31'd0, f}, 32'd1);
    chk("R5", "tbl np code", {29'd0, cd}, 32'd0);
  endtask

  task automatic t_prot;
    translate(32'h0040_6000, 1'b0, 1'b1, f, pa, cd, b, nr, nw);
    chk("R6", "user on sup page", {28'd0, f, cd}, 32'hD);
    chk("R7", "leaf untouched", peek(32'h2018), 32'h5555_5003);
    translate(32'h0040_7000, 1'b1, 1'b0, f, pa, cd, b, nr, nw);
    chk("R6", "sup write ro ok", {31'd0, f}, 32'd0);
    chk("R3", "paddr", pa, 32'h7777_7000);
    chk("R7", "leaf A+D", peek(32'h201C), 32'h7777_7065);
    translate(32'h0080_1000, 1'b1, 1'b1, f, pa, cd, b, nr, nw);
    chk("R6", "user write ro dir", {28'd0, f, cd}, 32'hF);
    chk("R7", "no write", 32'(nw), 32'd0);
    translate(32'h0080_1000, 1'b0, 1'b1, f, pa, cd, b, nr, nw);
    chk("R6", "user read ro dir ok", {31'd0, f}, 32'd0);
    chk("R2", "tbl addr via dir frame", rd_log[8'(b+1)], 32'h0000_3004);
    chk("R7", "dir then leaf", {peek(32'h1008)[15:0], peek(32'h3004)[15:0]}, 32'h3025_9027);
    translate(32'h8040_0000, 1'b0, 1'b1, f, pa, cd, b, nr, nw);
    chk("R6", "user on sup large", {28'd0, f, cd}, 32'hD);
    translate(32'h8040_0000, 1'b0, 1'b0, f, pa, cd, b, nr, nw);
    chk("R4", "sup large paddr", pa, 32'h4000_0000);
    chk("R7", "large read A only", peek(32'h1804), 32'h4000_00A3);
  endtask

  task automatic t_slow;
    slow = 1'b1;
    translate(32'h0040_8ABC, 1'b0, 1'b0, f, pa, cd, b, nr, nw);
    slow = 1'b0;
    chk("R9", "paddr with waits", pa, 32'h0BAD_FABC);
    chk("R9", "reads with waits", 32'(nr), 32'd2);
    chk("R9", "leaf write with waits", peek(32'h2020), 32'h0BAD_F021);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    poke(32'h1004, 32'h0000_2007);
    poke(32'h1008, 32'h0000_3005);
    poke(32'h1800, 32'hABC0_0087);
    poke(32'h1804, 32'h4000_0083);
    poke(32'h1C00, 32'h0000_0000);
    poke(32'h200C, 32'h1234_5E07);
    poke(32'h2014, 32'h0000_0000);
    poke(32'h2018, 32'h5555_5003);
    poke(32'h201C, 32'h7777_7005);
    poke(32'h2020, 32'h0BAD_F001);
    poke(32'h3004, 32'h9999_9007);
    t_small_read();
    t_small_write();
    t_large();
    t_np();
    t_prot();
    t_slow();
    summary();
    $finish;
  end
endmodule